// File: doc/BRIEF.md
# Page-Erasable Flash Array Model

This block is a synthesizable behavioural model of an embedded flash array. It sits behind a simple byte bus and serves two address windows from one storage array. The first window holds user code and data. The second holds a 48-byte block of interrupt vectors. Reads are combinational. A program strobe can only clear bits: the stored byte becomes the AND of the old byte and the write data. An erase strobe returns a whole 512-byte page to all ones. In the vector window it returns the whole vector block to all ones. Addresses outside both windows read as all ones and raise an access-error flag, and any program or erase aimed at them is dropped.

Every accepted operation holds a busy flag high for a fixed number of cycles. While that flag is high, new strobes are ignored. The user window starts at `USER_BASE` and spans `USER_PAGES` pages. The default is kept small at four pages, `$7000`–`$77FF`. Setting `USER_PAGES = 64` gives the full production window `$7000`–`$EFFF` of 32,768 bytes.

Top module: `flash_page_array`

## Requirements
- R1: After reset, every mapped address reads `$FF` and `busy_o` is low.
- R2: Addresses from `USER_BASE` up to `USER_BASE + USER_PAGES*512 - 1` map to the user storage. The default range is `$7000`–`$77FF`, and it becomes `$7000`–`$EFFF` with 64 pages.
- R3: Addresses `$FFD0`–`$FFFF` map to 48 vector bytes, which are separate from all user bytes.
- R4: A read at any address outside both windows returns `$FF` with `acc_err_o` high. Inside either window, `acc_err_o` is low.
- R5: An accepted program stores `old & wdata_i` at the addressed byte, so no bit ever goes from 0 to 1 without an erase.
- R6: An accepted erase in the user window sets to `$FF` all 512 bytes whose address shares `addr_i[15:9]`. All other pages are left unchanged.
- R7: An accepted erase anywhere in the vector window sets all 48 vector bytes to `$FF` and leaves the user bytes unchanged.
- R8: An accepted strobe raises `busy_o` from the next cycle, and `busy_o` stays high for exactly `BUSY_CYC` cycles (default 6).
- R9: A program or erase strobe seen while `busy_o` is high changes no byte and does not extend the busy period.
- R10: A program or erase strobe at an address outside both windows changes no byte and does not raise `busy_o`.
- R11: When `prog_i` and `erase_i` are both high, only the program is carried out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; sets the whole array to ones |
| addr_i | input | 16 | Byte address for reads, programs and erases |
| wdata_i | input | 8 | Data ANDed into the addressed byte on a program |
| prog_i | input | 1 | Program strobe, sampled on the rising clock edge |
| erase_i | input | 1 | Erase strobe, sampled on the rising clock edge |
| rdata_o | output | 8 | Combinational read data at `addr_i` |
| busy_o | output | 1 | High while an accepted operation is in progress |
| acc_err_o | output | 1 | High when `addr_i` lies outside both windows |

## Verification
The bench programs bytes in both windows with repeated and overlapping values. This separates a true AND-merge from plain overwrite or OR behaviour. It probes the first and last byte of each window and the byte just outside each edge, which exposes off-by-one decode errors and aliasing between the windows. It erases pages whose neighbours hold data, and aims erases at the vector block from a middle address. This shows whether page selection uses the right address bits and whether a vector erase reaches the user bytes. Strobes sent while busy, both strobes at once, strobes outside the windows and a long run of random operations are each checked against a byte-level reference model. A full scan of that model catches any stray write.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_USER = 2'd1,
    RGN_VEC  = 2'd2
  } region_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/flash_addr_decode.sv
module flash_addr_decode
  import flash_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned USER_BASE  = 16'h7000,
  parameter int unsigned USER_BYTES = 2048,
  parameter int unsigned VEC_BASE   = 16'hFFD0,
  parameter int unsigned VEC_BYTES  = 48,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned IDX_W      = 12,
  parameter int unsigned PG_W       = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [PG_W-1:0]   page_o
);
  localparam int unsigned PG_SHIFT = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W:0] U_LO = (ADDR_W+1)'(USER_BASE);
  localparam logic [ADDR_W:0] U_HI = (ADDR_W+1)'(USER_BASE + USER_BYTES);
  localparam logic [ADDR_W:0] V_LO = (ADDR_W+1)'(VEC_BASE);
  localparam logic [ADDR_W:0] V_HI = (ADDR_W+1)'(VEC_BASE + VEC_BYTES);

  logic [ADDR_W:0] a_ext, u_off, v_off;

  always_comb begin
    a_ext    = {1'b0, addr_i};
    u_off    = a_ext - U_LO;
    v_off    = a_ext - V_LO;
    region_o = RGN_NONE;
    idx_o    = '0;
    page_o   = '0;
    if (a_ext >= U_LO && a_ext < U_HI) begin
      region_o = RGN_USER;
      idx_o    = u_off[IDX_W-1:0];
      page_o   = PG_W'(u_off >> PG_SHIFT);
    end else if (a_ext >= V_LO && a_ext < V_HI) begin
      region_o = RGN_VEC;
      idx_o    = IDX_W'(USER_BYTES) + v_off[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int unsigned BUSY_CYC = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(BUSY_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_pkg::*;
#(
  parameter int unsigned USER_BYTES = 2048,
  parameter int unsigned VEC_BYTES  = 48,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned IDX_W      = 12,
  parameter int unsigned PG_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [PG_W-1:0]  page_i,
  input  logic [7:0]       wdata_i,
  input  logic             prog_i,
  input  logic             erase_user_i,
  input  logic             erase_vec_i,
  output logic [7:0]       rdata_o
);
  localparam int unsigned TOTAL = USER_BYTES + VEC_BYTES;

  logic [7:0] mem_q [TOTAL];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TOTAL; i++) mem_q[i] <= ERASED_BYTE;
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        if (i < USER_BYTES) begin
          if (erase_user_i && PG_W'(i / PAGE_BYTES) == page_i)
            mem_q[i] <= ERASED_BYTE;
          else if (prog_i && IDX_W'(i) == idx_i)
            mem_q[i] <= mem_q[i] & wdata_i;
        end else begin
          if (erase_vec_i)
            mem_q[i] <= ERASED_BYTE;
          else if (prog_i && IDX_W'(i) == idx_i)
            mem_q[i] <= mem_q[i] & wdata_i;
        end
      end
    end
  end

  assign rdata_o = (32'(idx_i) < TOTAL) ? mem_q[idx_i] : ERASED_BYTE;
endmodule

// File: rtl/flash_page_array.sv
module flash_page_array
  import flash_pkg::*;
#(
  parameter int unsigned USER_BASE  = 16'h7000,
  parameter int unsigned USER_PAGES = 4,
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned VEC_BASE   = 16'hFFD0,
  parameter int unsigned VEC_BYTES  = 48,
  parameter int unsigned BUSY_CYC   = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        prog_i,
  input  logic        erase_i,
  output logic [7:0]  rdata_o,
  output logic        busy_o,
  output logic        acc_err_o
);
  localparam int unsigned USER_BYTES = USER_PAGES * PAGE_BYTES;
  localparam int unsigned TOTAL      = USER_BYTES + VEC_BYTES;
  localparam int unsigned IDX_W      = $clog2(TOTAL);
  localparam int unsigned PG_W       = (USER_PAGES > 1) ? $clog2(USER_PAGES) : 1;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic [PG_W-1:0]  page;
  logic [7:0]       store_rd;
  logic             in_rgn, go, do_prog, do_erase;

  flash_addr_decode #(
    .ADDR_W(16), .USER_BASE(USER_BASE), .USER_BYTES(USER_BYTES),
    .VEC_BASE(VEC_BASE), .VEC_BYTES(VEC_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .IDX_W(IDX_W), .PG_W(PG_W)
  ) u_dec (
    .addr_i(addr_i), .region_o(region), .idx_o(idx), .page_o(page)
  );

  assign in_rgn   = (region != RGN_NONE);
  assign go       = in_rgn && !busy_o;
  // program wins over a simultaneous erase
  assign do_prog  = go && prog_i;
  assign do_erase = go && erase_i && !prog_i;

  flash_store #(
    .USER_BYTES(USER_BYTES), .VEC_BYTES(VEC_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .IDX_W(IDX_W), .PG_W(PG_W)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(idx), .page_i(page),
    .wdata_i(wdata_i), .prog_i(do_prog),
    .erase_user_i(do_erase && region == RGN_USER),
    .erase_vec_i(do_erase && region == RGN_VEC),
    .rdata_o(store_rd)
  );

  flash_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(do_prog || do_erase), .busy_o(busy_o)
  );

  assign rdata_o   = in_rgn ? store_rd : ERASED_BYTE;
  assign acc_err_o = !in_rgn;
endmodule

// File: rtl/flash_page_array_chk.sv
module flash_page_array_chk #(
  parameter int unsigned BUSY_CYC = 6
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic        prog_i,
  input logic        erase_i,
  input logic [7:0]  rdata_o,
  input logic        busy_o,
  input logic        acc_err_o
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= 0;
  end

  // R8
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == BUSY_CYC);

  // R4
  err_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_err_o |-> rdata_o == 8'hFF);

  // R10
  out_no_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_err_o && !busy_o) |=> !busy_o);

  // R8
  idle_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !prog_i && !erase_i) |=> !busy_o);

  // R5
  prog_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && prog_i && !acc_err_o) |=>
      ($stable(addr_i) -> rdata_o == ($past(rdata_o) & $past(wdata_i))));

  // R5
  no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!erase_i || busy_o) |=>
      ($stable(addr_i) -> (rdata_o & ~$past(rdata_o)) == 8'h00));
endmodule

bind flash_page_array flash_page_array_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .prog_i(prog_i), .erase_i(erase_i), .rdata_o(rdata_o),
  .busy_o(busy_o), .acc_err_o(acc_err_o)
);

// File: tb/sim_flash_page_array.sv
module sim_flash_page_array;
  localparam int CLK_PERIOD = 10;
  localparam int USER_BASE  = 'h7000;
  localparam int USER_BYTES = 2048;
  localparam int VEC_BASE   = 'hFFD0;
  localparam int VEC_BYTES  = 48;
  localparam int TOTAL      = USER_BYTES + VEC_BYTES;
  localparam int BUSY_CYC   = 6;

  logic        clk_i = 0, rst_ni = 0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        prog_i = 0, erase_i = 0;
  logic [7:0]  rdata_o;
  logic        busy_o, acc_err_o;

  int total = 0, bad = 0;
  logic [7:0] ref_mem [TOTAL];

  flash_page_array u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .prog_i(prog_i), .erase_i(erase_i), .rdata_o(rdata_o),
    .busy_o(busy_o), .acc_err_o(acc_err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int map_addr(input int a);
    if (a >= USER_BASE && a < USER_BASE + USER_BYTES) return a - USER_BASE;
    if (a >= VEC_BASE && a < VEC_BASE + VEC_BYTES) return USER_BYTES + a - VEC_BASE;
    return -1;
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    int m = map_addr(a);
    return (m < 0) ? 8'hFF : ref_mem[m];
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input int a);
    addr_i = 16'(a);
    #1;
    check(tag, {23'd0, acc_err_o, rdata_o}, {23'd0, (map_addr(a) < 0), exp_read(a)});
  endtask

  task automatic ref_apply(input int a, input logic [7:0] d, input bit p, input bit e);
    int m = map_addr(a);
    if (m < 0) return;
    if (p) ref_mem[m] = ref_mem[m] & d;
    else if (e) begin
      if (m < USER_BYTES) begin
        for (int j = (m / 512) * 512; j < (m / 512) * 512 + 512; j++) ref_mem[j] = 8'hFF;
      end else begin
        for (int j = USER_BYTES; j < TOTAL; j++) ref_mem[j] = 8'hFF;
      end
    end
  endtask

  // poke: send a program of $00 to poke_a during the first busy cycle
  task automatic do_op(input string tag, input int a, input logic [7:0] d,
                       input bit p, input bit e, input bit poke, input int poke_a);
    int n;
    bit acc;
    @(negedge clk_i);
    addr_i = 16'(a); wdata_i = d; prog_i = p; erase_i = e;
    acc = (map_addr(a) >= 0) && (p || e);
    @(negedge clk_i);
    prog_i = 0; erase_i = 0;
    ref_apply(a, d, p, e);
    check({tag, " busy start"}, busy_o, acc);
    n = 0;
    while (busy_o && n < 1000) begin
      if (poke && n == 0) begin
        addr_i = 16'(poke_a); wdata_i = 8'h00; prog_i = 1; erase_i = 1;
      end
      n++;
      @(negedge clk_i);
      prog_i = 0; erase_i = 0;
    end
    if (acc) check({tag, " busy len R8"}, n, BUSY_CYC);
    rd_chk(tag, a);
  endtask

  task automatic scan_all(input string tag);
    int errs = 0;
    for (int i = 0; i < TOTAL; i++) begin
      int a = (i < USER_BYTES) ? USER_BASE + i : VEC_BASE + i - USER_BYTES;
      addr_i = 16'(a);
      #1;
      if (rdata_o !== ref_mem[i] || acc_err_o !== 1'b0) errs++;
    end
    check({tag, " full scan mismatches"}, errs, 0);
  endtask

  function automatic int rand_addr();
    int k = $urandom % 3;
    if (k == 0) return USER_BASE + ($urandom % USER_BYTES);
    if (k == 1) return VEC_BASE + ($urandom % VEC_BYTES);
    return $urandom % USER_BASE;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < TOTAL; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 busy after reset", busy_o, 0);
    scan_all("R1");
    // R2 / R4 window edges
    rd_chk("R2 user low edge", 'h7000);
    rd_chk("R2 user high edge", 'h77FF);
    rd_chk("R4 below user", 'h6FFF);
    rd_chk("R4 above user", 'h7800);
    rd_chk("R4 below vector", 'hFFCF);
    rd_chk("R3 vector top", 'hFFFF);
    // R5 AND merge
    do_op("R5 prog first", 'h7000, 8'hA5, 1, 0, 0, 0);
    do_op("R5 prog AND", 'h7000, 8'h3C, 1, 0, 0, 0);
    do_op("R5 prog ones no set", 'h7000, 8'hFF, 1, 0, 0, 0);
    do_op("R2 prog high edge", 'h77FF, 8'h5A, 1, 0, 0, 0);
    do_op("R2 prog page1", 'h7200, 8'h11, 1, 0, 0, 0);
    // R3 vector storage distinct
    do_op("R3 prog vec top", 'hFFFF, 8'h12, 1, 0, 0, 0);
    do_op("R3 prog vec low", 'hFFD0, 8'h34, 1, 0, 0, 0);
    rd_chk("R3 user untouched", 'h7000);
    // R6 page erase from mid-page address
    do_op("R6 erase page0", 'h71FF, 8'h00, 0, 1, 0, 0);
    rd_chk("R6 page0 first byte", 'h7000);
    rd_chk("R6 page1 kept", 'h7200);
    rd_chk("R6 page3 kept", 'h77FF);
    // R7 vector erase
    do_op("R7 erase vector", 'hFFE0, 8'h00, 0, 1, 0, 0);
    rd_chk("R7 vec low", 'hFFD0);
    rd_chk("R7 user kept", 'h7200);
    // R10 outside strobes
    do_op("R10 prog outside", 'h0000, 8'h00, 1, 0, 0, 0);
    do_op("R10 erase outside", 'hF000, 8'h00, 0, 1, 0, 0);
    scan_all("R10");
    // R9 strobe during busy
    do_op("R9 prog with poke", 'h7400, 8'hF0, 1, 0, 1, 'h7201);
    rd_chk("R9 poked byte unchanged", 'h7201);
    rd_chk("R9 page1 not erased", 'h7200);
    // R11 both strobes
    do_op("R11 both strobes", 'h7201, 8'h0F, 1, 1, 0, 0);
    rd_chk("R11 page1 kept", 'h7200);
    // random mix
    for (int it = 0; it < 400; it++) begin
      int a = rand_addr();
      int k = $urandom % 8;
      do_op("R5 R6 R7 random", a, 8'($urandom), k != 0, k == 0 || k == 7, it % 37 == 0, rand_addr());
    end
    scan_all("R6 R7 random");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule